// File: doc/BRIEF.md
# Parallel Counter-Mode Keystream Generator

This block produces 128-bit keystream words for counter-mode encryption by running a bank of identical block-cipher cores side by side. A shared counter base is loaded from a 128-bit seed. Each core, when its start strobe is accepted, encrypts its own counter value: the base plus the core's index. When the last core of the bank is started, the base moves forward by the number of cores in one step. Finished results are written into a keystream FIFO, and a consumer pops them to XOR with data.

The cipher here is a keyed placeholder with a fixed number of iterative rounds, so the bank's dispatch, ordering and flow control can be built and checked without the real cipher. The 256-bit key is used as given; key expansion is assumed to have been done once per session, before the bank runs, and the key is held steady while any core is busy. A synchronous flush empties the FIFO and stops every core, while the counter base is kept.

Top module: `ctr_keystream_bank`

## Requirements
- R1: For counter c and key K the keystream word is E(K,c): x = c XOR K[127:0], then LAT times (default 4) x = rotate-left-by-3(x) + K[255:128] modulo 2^128; keystream words and counters are 128 bits, the key is 256 bits.
- R2: When `load_iv` is high at a clock edge, the counter base takes `seed_iv`; this wins over an advance in the same cycle.
- R3: An accepted start on bit j of `core_start` (j = 0 to NCORES-1; bit NCORES-1 is the last core) makes that core encrypt base + j modulo 2^128, using the base value at that edge.
- R4: An accepted start on the last core, with no load in the same cycle, advances the base by NCORES modulo 2^128.
- R5: `core_done[j]` goes high for exactly one cycle, after LAT further edges following the accepting edge; the result is in the FIFO after the next edge.
- R6: Results of cores finishing in the same cycle enter the FIFO in ascending core index; results finishing in different cycles enter in finishing order; the FIFO is first-in first-out.
- R7: A start strobe on a core that is still busy is ignored.
- R8: Starts are accepted in a cycle only if FIFO count + busy cores + NCORES is at most DEPTH (default 64); otherwise all starts of that cycle are ignored and the base does not move.
- R9: `ks_data` shows the oldest entry while `ks_empty` is low; `pop` removes it; `pop` on an empty FIFO is ignored and `ks_count` holds the number of entries.
- R10: `flush` high at an edge empties the FIFO and returns all cores to idle; the counter base keeps its value.
- R11: After reset the FIFO is empty, `ks_count` is 0, no `core_done` bit is high and the base is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| flush | input | 1 | Synchronous clear of FIFO and cores |
| key | input | 256 | Session key, held while cores run |
| seed_iv | input | 128 | Seed for the counter base |
| load_iv | input | 1 | Load `seed_iv` into the counter base |
| core_start | input | NCORES | Per-core start strobes, bit j = core j |
| pop | input | 1 | Remove the oldest keystream word |
| ks_data | output | 128 | Oldest keystream word |
| ks_empty | output | 1 | FIFO holds no word |
| ks_count | output | clog2(DEPTH+1) | Number of words in the FIFO |
| core_done | output | NCORES | Per-core one-cycle completion pulses |

## Verification
The whole bank is started in one cycle from an ordinary seed and from a seed three below the 128-bit wrap, which separates correct per-core offsets, base stepping and modulo wrap from an off-by-one or a missing carry. Two cores started one cycle apart in reverse index order tell finishing-order collection apart from plain index priority, while a single-core start timed edge by edge pins the latency and pulse width. Repeated strobes on a busy core, a third full batch against a nearly full FIFO, a start that coincides with a seed load, pops on an empty FIFO and a flush followed by a fresh start each show whether the ignored input truly changed nothing.

// File: rtl/ctrks_pkg.sv
// Shared definitions for the parallel counter-mode keystream bank.
// Assumes: key width is twice the word width (upper half is the round addend).
package ctrks_pkg;
    localparam int unsigned WORD_W_DEF = 128;
    localparam int unsigned KEY_W_DEF  = 256;
    localparam int unsigned ROT_AMT    = 3;

    typedef enum logic [0:0] {
        CORE_IDLE = 1'b0,
        CORE_RUN  = 1'b1
    } core_state_e;
endpackage

// File: rtl/ctrks_base.sv
// Counter base register and per-core counter offsets.
// Loads the seed on load, otherwise steps by NCORES on advance.
// Assumes: load has priority over advance.
module ctrks_base #(
    parameter int unsigned W      = 128,
    parameter int unsigned NCORES = 26
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       load,
    input  logic [W-1:0]               seed,
    input  logic                       advance,
    output logic [NCORES-1:0][W-1:0]   ctrs
);
    logic [W-1:0] base_q;

    // Base register: seed load, bank-wide step, or hold.
    always_ff @(posedge clk) begin
        if (!rst_n)       base_q <= '0;
        else if (load)    base_q <= seed;
        else if (advance) base_q <= base_q + W'(NCORES);
    end

    // Each core's counter is the base plus its index, modulo 2^W.
    for (genvar j = 0; j < NCORES; j++) begin : g_off
        assign ctrs[j] = base_q + W'(j);
    end

    AST_SEED_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
        load |=> base_q == $past(seed)); // R2
    AST_BASE_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        (!load && advance) |=> base_q == $past(base_q) + W'(NCORES)); // R4
    AST_BASE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (!load && !advance) |=> $stable(base_q)); // R10
endmodule

// File: rtl/ctrks_core.sv
// Placeholder iterative block cipher with a fixed round count.
// Start: x = ctr ^ key_lo; each following cycle one round
// x = rotl(x, ROT_AMT) + key_hi; done pulses when LAT rounds are in.
// Assumes: start is only raised while idle; key is stable while running.
module ctrks_core
    import ctrks_pkg::*;
#(
    parameter int unsigned W   = 128,
    parameter int unsigned KW  = 256,
    parameter int unsigned LAT = 4
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          flush,
    input  logic [KW-1:0] key,
    input  logic          start,
    input  logic [W-1:0]  ctr,
    output logic          busy,
    output logic          done,
    output logic [W-1:0]  result
);
    localparam int unsigned RW = $clog2(LAT + 1);

    core_state_e   state_q;
    logic [RW-1:0] rnd_q;
    logic [W-1:0]  x_q;
    logic [W-1:0]  x_next;

    // One cipher round on the current state.
    always_comb begin
        x_next = {x_q[W-1-ROT_AMT:0], x_q[W-1:W-ROT_AMT]} + key[KW-1 -: W];
    end

    // Round sequencing: load on start, iterate, release after done.
    always_ff @(posedge clk) begin
        if (!rst_n || flush) begin
            state_q <= CORE_IDLE;
            rnd_q   <= '0;
            x_q     <= '0;
        end else if (state_q == CORE_IDLE) begin
            if (start) begin
                state_q <= CORE_RUN;
                rnd_q   <= '0;
                x_q     <= ctr ^ key[W-1:0];
            end
        end else if (rnd_q == RW'(LAT)) begin
            state_q <= CORE_IDLE;
        end else begin
            x_q   <= x_next;
            rnd_q <= rnd_q + 1'b1;
        end
    end

    assign busy   = (state_q == CORE_RUN);
    assign done   = busy && (rnd_q == RW'(LAT));
    assign result = x_q;

    AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done); // R5
    AST_RUN_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && !done && !flush) |=> busy); // R7
endmodule

// File: rtl/ctrks_ofifo.sv
// Keystream FIFO with one write port per core. All results arriving in a
// cycle are placed at consecutive slots in ascending core index.
// Assumes: DEPTH is a power of two; the caller never offers more words
// than there is room for.
module ctrks_ofifo #(
    parameter int unsigned W      = 128,
    parameter int unsigned DEPTH  = 64,
    parameter int unsigned NCORES = 26
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       flush,
    input  logic [NCORES-1:0]          wr_vec,
    input  logic [NCORES-1:0][W-1:0]   wr_data,
    input  logic                       pop,
    output logic [W-1:0]               rd_data,
    output logic                       empty,
    output logic [$clog2(DEPTH+1)-1:0] count
);
    localparam int unsigned AW = $clog2(DEPTH);
    localparam int unsigned CW = $clog2(DEPTH + 1);

    logic [W-1:0]  mem [DEPTH];
    logic [AW-1:0] wr_ptr_q, rd_ptr_q;
    logic [CW-1:0] count_q;
    logic [AW-1:0] waddr [NCORES];
    logic [CW-1:0] nwr;
    logic          pop_ok;

    // Slot for each writer: write pointer plus the number of lower writers.
    always_comb begin
        logic [AW-1:0] run;
        run = '0;
        for (int j = 0; j < NCORES; j++) begin
            waddr[j] = wr_ptr_q + run;
            run      = run + AW'(wr_vec[j]);
        end
    end

    assign nwr    = CW'($countones(wr_vec));
    assign pop_ok = pop && (count_q != '0);

    // Storage writes, one per finishing core.
    always_ff @(posedge clk) begin
        if (rst_n && !flush) begin
            for (int j = 0; j < NCORES; j++) begin
                if (wr_vec[j]) mem[waddr[j]] <= wr_data[j];
            end
        end
    end

    // Pointer and occupancy bookkeeping.
    always_ff @(posedge clk) begin
        if (!rst_n || flush) begin
            wr_ptr_q <= '0;
            rd_ptr_q <= '0;
            count_q  <= '0;
        end else begin
            wr_ptr_q <= wr_ptr_q + nwr[AW-1:0];
            rd_ptr_q <= rd_ptr_q + AW'(pop_ok);
            count_q  <= count_q + nwr - CW'(pop_ok);
        end
    end

    assign rd_data = mem[rd_ptr_q];
    assign empty   = (count_q == '0);
    assign count   = count_q;

    AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
        count_q <= CW'(DEPTH)); // R8
    AST_FLUSH_EMPTY: assert property (@(posedge clk) disable iff (!rst_n)
        flush |=> count_q == '0); // R10
    AST_POP_EMPTY: assert property (@(posedge clk) disable iff (!rst_n)
        (!flush && count_q == '0 && pop && wr_vec == '0) |=> count_q == '0); // R9
endmodule

// File: rtl/ctr_keystream_bank.sv
// Parallel counter-mode keystream generator: a bank of NCORES cipher cores
// fed consecutive counters from a shared base, results collected in order
// into a keystream FIFO.
// Assumes: key is stable while any core runs; DEPTH >= NCORES, power of two.
module ctr_keystream_bank
    import ctrks_pkg::*;
#(
    parameter int unsigned W      = WORD_W_DEF,
    parameter int unsigned KW     = KEY_W_DEF,
    parameter int unsigned NCORES = 26,
    parameter int unsigned LAT    = 4,
    parameter int unsigned DEPTH  = 64
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       flush,
    input  logic [KW-1:0]              key,
    input  logic [W-1:0]               seed_iv,
    input  logic                       load_iv,
    input  logic [NCORES-1:0]          core_start,
    input  logic                       pop,
    output logic [W-1:0]               ks_data,
    output logic                       ks_empty,
    output logic [$clog2(DEPTH+1)-1:0] ks_count,
    output logic [NCORES-1:0]          core_done
);
    localparam int unsigned CW = $clog2(DEPTH + 1);

    logic [NCORES-1:0][W-1:0] ctrs;
    logic [NCORES-1:0][W-1:0] results;
    logic [NCORES-1:0]        busy_v;
    logic [NCORES-1:0]        done_v;
    logic [NCORES-1:0]        accept;
    logic [CW:0]              occ;
    logic                     room_ok;

    // Room check: stored words plus words still in flight plus a full batch.
    always_comb begin
        occ     = {1'b0, ks_count} + (CW+1)'($countones(busy_v));
        room_ok = occ <= (CW+1)'(DEPTH - NCORES);
        accept  = core_start & ~busy_v & {NCORES{room_ok && !flush}};
    end

    ctrks_base #(.W(W), .NCORES(NCORES)) u_base (
        .clk     (clk),
        .rst_n   (rst_n),
        .load    (load_iv),
        .seed    (seed_iv),
        .advance (accept[NCORES-1]),
        .ctrs    (ctrs)
    );

    for (genvar j = 0; j < NCORES; j++) begin : g_core
        ctrks_core #(.W(W), .KW(KW), .LAT(LAT)) u_core (
            .clk    (clk),
            .rst_n  (rst_n),
            .flush  (flush),
            .key    (key),
            .start  (accept[j]),
            .ctr    (ctrs[j]),
            .busy   (busy_v[j]),
            .done   (done_v[j]),
            .result (results[j])
        );
    end

    ctrks_ofifo #(.W(W), .DEPTH(DEPTH), .NCORES(NCORES)) u_fifo (
        .clk     (clk),
        .rst_n   (rst_n),
        .flush   (flush),
        .wr_vec  (done_v),
        .wr_data (results),
        .pop     (pop),
        .rd_data (ks_data),
        .empty   (ks_empty),
        .count   (ks_count)
    );

    assign core_done = done_v;

    AST_DONE_IDLE_AFTER: assert property (@(posedge clk) disable iff (!rst_n)
        (core_done != '0) |=> (core_done & $past(core_done)) == '0); // R5
endmodule

// File: tb/tb_ctr_keystream_bank.sv
module tb_ctr_keystream_bank;
    localparam int    N       = 26;
    localparam int    LAT     = 4;
    localparam int    DEPTH   = 64;
    localparam time   CLK_PER = 10ns;

    logic             clk = 0;
    logic             rst_n = 0;
    logic             flush = 0;
    logic [255:0]     key;
    logic [127:0]     seed_iv = '0;
    logic             load_iv = 0;
    logic [N-1:0]     core_start = '0;
    logic             pop = 0;
    logic [127:0]     ks_data;
    logic             ks_empty;
    logic [6:0]       ks_count;
    logic [N-1:0]     core_done;

    int n_cmp = 0;
    int n_bad = 0;

    ctr_keystream_bank #(.W(128), .KW(256), .NCORES(N), .LAT(LAT), .DEPTH(DEPTH)) dut (
        .clk(clk), .rst_n(rst_n), .flush(flush), .key(key), .seed_iv(seed_iv),
        .load_iv(load_iv), .core_start(core_start), .pop(pop), .ks_data(ks_data),
        .ks_empty(ks_empty), .ks_count(ks_count), .core_done(core_done)
    );

    always #(CLK_PER/2) clk = ~clk;

    // Keystream word for counter c as defined in R1.
    function automatic logic [127:0] ks_ref(input logic [127:0] c);
        logic [127:0] x;
        x = c ^ key[127:0];
        for (int r = 0; r < LAT; r++) x = {x[124:0], x[127:125]} + key[255:128];
        return x;
    endfunction

    task automatic chk(input string req, input logic [127:0] act, input logic [127:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic step(input int n = 1);
        repeat (n) @(negedge clk);
    endtask

    task automatic fire(input logic [N-1:0] m);
        core_start = m;
        step();
        core_start = '0;
    endtask

    task automatic load(input logic [127:0] s);
        seed_iv = s; load_iv = 1;
        step();
        load_iv = 0;
    endtask

    // Pop n words, comparing each with the expected counter sequence.
    task automatic drain(input string req, input logic [127:0] ctrs[$]);
        foreach (ctrs[i]) begin
            chk(req, ks_data, ks_ref(ctrs[i]));
            pop = 1;
            step();
        end
        pop = 0;
    endtask

    task automatic t_reset();
        logic [127:0] q[$];
        chk("R11 empty", 128'(ks_empty), 128'd1);
        chk("R11 count", 128'(ks_count), 128'd0);
        chk("R11 done", 128'(core_done), 128'd0);
        fire(N'(1));
        step(LAT + 2);
        q = '{128'd0};
        drain("R11 base zero", q);
    endtask

    task automatic t_latency();
        fire(N'(1));
        for (int k = 1; k <= LAT; k++) begin
            chk("R5 done early", 128'(core_done[0]), 128'd0);
            step();
        end
        chk("R5 done high", 128'(core_done[0]), 128'd1);
        chk("R5 not yet stored", 128'(ks_empty), 128'd1);
        step();
        chk("R5 done one cycle", 128'(core_done[0]), 128'd0);
        chk("R5 stored", 128'(ks_count), 128'd1);
        pop = 1; step(); pop = 0;
    endtask

    task automatic t_full_batch(input logic [127:0] s, input string req);
        logic [127:0] q[$];
        load(s);
        fire('1);
        step(LAT + 2);
        chk({req, " count"}, 128'(ks_count), 128'(N));
        for (int j = 0; j < N; j++) q.push_back(s + 128'(j));
        drain({req, " order"}, q);
        q.delete();
        fire('1);
        step(LAT + 2);
        for (int j = 0; j < N; j++) q.push_back(s + 128'(N + j));
        drain("R4 second batch", q);
    endtask

    task automatic t_stagger();
        logic [127:0] s;
        logic [127:0] q[$];
        s = 128'h0123_4567_89ab_cdef_0f1e_2d3c_4b5a_6978;
        load(s);
        fire(N'(1) << 5);
        fire(N'(1) << 2);
        step(LAT + 2);
        q = '{s + 128'd5, s + 128'd2};
        drain("R6 finish order", q);
    endtask

    task automatic t_busy();
        logic [127:0] s;
        logic [127:0] q[$];
        s = 128'd1000;
        load(s);
        fire(N'(1) << 3);
        fire(N'(1) << 3);
        fire(N'(1) << 3);
        step(LAT + 2);
        chk("R7 busy restart ignored", 128'(ks_count), 128'd1);
        q = '{s + 128'd3};
        drain("R7 value", q);
    endtask

    task automatic t_room_flush();
        logic [127:0] s;
        logic [127:0] q[$];
        s = 128'h5000;
        load(s);
        fire('1);
        step(LAT + 2);
        fire('1);
        step(LAT + 2);
        chk("R8 two batches", 128'(ks_count), 128'd52);
        fire('1);
        step(LAT + 2);
        chk("R8 batch refused", 128'(ks_count), 128'd52);
        chk("R9 head", ks_data, ks_ref(s));
        flush = 1; step(); flush = 0;
        chk("R10 flushed count", 128'(ks_count), 128'd0);
        chk("R10 flushed empty", 128'(ks_empty), 128'd1);
        fire(N'(1));
        step(LAT + 2);
        q = '{s + 128'd52};
        drain("R10 base kept", q);
    endtask

    task automatic t_flush_midrun();
        fire(N'(1) << 7);
        step(2);
        flush = 1; step(); flush = 0;
        step(LAT + 2);
        chk("R10 core idled", 128'(ks_count), 128'd0);
    endtask

    task automatic t_pop_empty();
        logic [127:0] s;
        logic [127:0] q[$];
        pop = 1; step(3); pop = 0;
        chk("R9 pop empty count", 128'(ks_count), 128'd0);
        chk("R9 pop empty flag", 128'(ks_empty), 128'd1);
        s = 128'h77;
        load(s);
        fire(N'(1) << 1);
        step(LAT + 2);
        chk("R9 count after write", 128'(ks_count), 128'd1);
        q = '{s + 128'd1};
        drain("R9 data", q);
    endtask

    task automatic t_load_priority();
        logic [127:0] s1, s2;
        logic [127:0] q[$];
        s1 = 128'hAAAA_0000; s2 = 128'hBBBB_0000;
        load(s1);
        seed_iv = s2; load_iv = 1; core_start = '1;
        step();
        load_iv = 0; core_start = '0;
        step(LAT + 2);
        for (int j = 0; j < N; j++) q.push_back(s1 + 128'(j));
        drain("R3 old base used", q);
        fire(N'(1));
        step(LAT + 2);
        q.delete();
        q.push_back(s2);
        drain("R2 load wins", q);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog: actual timeout expected finish");
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        key = {128'h9e37_79b9_7f4a_7c15_f39c_c060_5ced_c834,
               128'h1082_2765_3f0e_4d6b_a5a5_c3c3_0f0f_1234};
        step(3);
        rst_n = 1;
        step();
        t_reset();
        t_latency();
        t_full_batch(128'h0000_0000_0000_0000_0000_0001_0000_0000, "R1 R3 plain");
        t_full_batch(~128'd2, "R3 wrap");
        t_stagger();
        t_busy();
        t_room_flush();
        t_flush_midrun();
        t_pop_empty();
        t_load_priority();
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule